// File: doc/BRIEF.md
# Vector Load-Operand Expander

This block sits between a memory read port and a vector execution pipeline. It takes one raw fetch of up to one full vector of bytes, the byte address of that fetch and a three-bit operation code, and produces a source operand of LANES 32-bit lanes. The code selects one of six shapes: a straight full-width load, a single 32-bit element copied into every lane, a group of four consecutive 32-bit elements repeated along the vector, half-precision floats widened to single precision, or 8-bit or 16-bit integers widened to 32 bits. A separate input picks sign or zero extension for the two integer shapes. Copying and widening are exclusive: a code that would ask for both is rejected.

Each shape fetches a block of a known size before any masking happens later in the pipeline, and the address must be a multiple of that size. A misaligned or illegal request raises a fault flag and delivers an all-zero operand. The result appears one clock after the request, registered, with a valid strobe.

Top module: `ldop_expander`

## Requirements
- R1: Code 0 (full load) delivers lane i = input bits [32i+31:32i] for every lane; the address must be a multiple of LANES*4 bytes.
- R2: Code 1 (single broadcast) copies input bits [31:0] into every lane; the address must be a multiple of 4 bytes.
- R3: Code 2 (group broadcast) delivers lane i = input element (i mod 4), element j being bits [32j+31:32j]; the address must be a multiple of 16 bytes.
- R4: Code 3 (half-float widen) turns input halfword i, bits [16i+15:16i], into a single-precision value in lane i, exactly for signed zeros, normals and infinities; the address must be a multiple of LANES*2 bytes.
- R5: In code 3, half-precision subnormal inputs come out as normalised single-precision values of the same magnitude.
- R6: In code 3, a NaN keeps its sign, gets an all-ones exponent and has its 10-bit fraction placed in the top 10 fraction bits, so the quiet bit is kept.
- R7: Code 4 (byte widen) turns input byte i, bits [8i+7:8i], into lane i, sign-extended when in_sign_ext is 1 and zero-extended when it is 0; the address must be a multiple of LANES bytes.
- R8: Code 5 (halfword widen) turns input halfword i into lane i with sign or zero extension chosen by in_sign_ext; the address must be a multiple of LANES*2 bytes.
- R9: A request whose address breaks its code's alignment sets out_fault and forces out_vec to zero.
- R10: Codes 6 and 7 (broadcast combined with widening) are illegal at any address: out_fault is set and out_vec is zero.
- R11: out_valid follows in_valid one clock later; on a cycle with out_valid low, out_fault is 0 and out_vec is zero.
- R12: While rst is high and on the first cycle after, out_valid, out_fault and out_vec are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | LANES*32 | Raw fetched bytes, little-endian |
| in_addr | input | AW | Byte address of the fetch |
| in_mode | input | 3 | Operation code, 0 to 7 |
| in_sign_ext | input | 1 | 1 = sign extend, 0 = zero extend (codes 4, 5) |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_vec | output | LANES*32 | Expanded operand |
| out_fault | output | 1 | Alignment or illegal-code fault |

## Verification
The bench builds the block with LANES=16, GROUP=4 and AW=16, so the four alignment sizes in use (4, 16, 32 and 64 bytes) are all different and an address can be picked that satisfies one shape and breaks the next larger one. The half-float run packs zeros of both signs, subnormals at both ends of their range, the extreme normals, infinities and quiet and signalling NaNs into one sixteen-lane fetch. Both integer widths are run with top-bit-set and top-bit-clear values under sign and zero extension, and requests go back to back so that a stale lane would show.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    localparam int ELEM_W = 32;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        LD_FULL   = 3'd0,
        LD_BC1    = 3'd1,
        LD_BC4    = 3'd2,
        LD_F16    = 3'd3,
        LD_INT8   = 3'd4,
        LD_INT16  = 3'd5,
        LD_BAD6   = 3'd6,
        LD_BAD7   = 3'd7
    } ld_mode_e;

    typedef struct packed {
        logic       sign;
        logic [4:0] expo;
        logic [9:0] frac;
    } half_t;

    typedef struct packed {
        logic       sign;
        logic [7:0] expo;
        logic [22:0] frac;
    } single_t;

    function automatic logic mode_is_widen(input ld_mode_e m);
        return (m == LD_F16) || (m == LD_INT8) || (m == LD_INT16);
    endfunction

    function automatic logic mode_is_legal(input ld_mode_e m);
        return (m != LD_BAD6) && (m != LD_BAD7);
    endfunction

    function automatic single_t half_to_single(input half_t h);
        single_t    r;
        int         lead;
        logic [9:0] norm;
        r.sign = h.sign;
        lead   = 0;
        norm   = '0;
        if (h.expo == 5'd0) begin
            if (h.frac == 10'd0) begin
                r.expo = 8'd0;
                r.frac = 23'd0;
            end else begin
                for (int b = 0; b < 10; b++) begin
                    if (h.frac[b]) lead = b;
                end
                norm   = 10'(h.frac << (10 - lead));
                r.expo = 8'(lead + 103);
                r.frac = {norm, 13'd0};
            end
        end else if (h.expo == 5'h1F) begin
            r.expo = 8'hFF;
            r.frac = {h.frac, 13'd0};
        end else begin
            r.expo = 8'({3'd0, h.expo} + 8'd112);
            r.frac = {h.frac, 13'd0};
        end
        return r;
    endfunction

endpackage

// File: rtl/ldx_replicate.sv
module ldx_replicate
    import ldx_pkg::*;
#(
    parameter int LANES = 16,
    parameter int GROUP = 4
) (
    input  logic [LANES*ELEM_W-1:0] src,
    input  ld_mode_e                mode,
    output logic [LANES*ELEM_W-1:0] vec
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int GI = i % GROUP;
        always_comb begin
            unique case (mode)
                LD_FULL: vec[i*ELEM_W +: ELEM_W] = src[i*ELEM_W  +: ELEM_W];
                LD_BC1:  vec[i*ELEM_W +: ELEM_W] = src[0         +: ELEM_W];
                LD_BC4:  vec[i*ELEM_W +: ELEM_W] = src[GI*ELEM_W +: ELEM_W];
                default: vec[i*ELEM_W +: ELEM_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/ldx_upconv.sv
module ldx_upconv
    import ldx_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [LANES*HALF_W-1:0] src,
    input  ld_mode_e                mode,
    input  logic                    sign_ext,
    output logic [LANES*ELEM_W-1:0] vec
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [HALF_W-1:0] hw;
        logic [BYTE_W-1:0] by;
        single_t           fl;
        logic [ELEM_W-1:0] w8;
        logic [ELEM_W-1:0] w16;

        assign hw = src[i*HALF_W +: HALF_W];
        assign by = src[i*BYTE_W +: BYTE_W];
        assign fl = half_to_single(half_t'(hw));
        assign w8  = {{(ELEM_W-BYTE_W){sign_ext & by[BYTE_W-1]}}, by};
        assign w16 = {{(ELEM_W-HALF_W){sign_ext & hw[HALF_W-1]}}, hw};

        always_comb begin
            unique case (mode)
                LD_F16:   vec[i*ELEM_W +: ELEM_W] = fl;
                LD_INT8:  vec[i*ELEM_W +: ELEM_W] = w8;
                LD_INT16: vec[i*ELEM_W +: ELEM_W] = w16;
                default:  vec[i*ELEM_W +: ELEM_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/ldx_align_chk.sv
module ldx_align_chk
    import ldx_pkg::*;
#(
    parameter int LANES = 16,
    parameter int GROUP = 4,
    parameter int AW    = 16
) (
    input  logic [AW-1:0] addr,
    input  ld_mode_e      mode,
    output logic          fault
);

    localparam int FULL_BYTES = LANES * (ELEM_W / 8);
    localparam int ONE_BYTES  = ELEM_W / 8;
    localparam int GRP_BYTES  = GROUP * (ELEM_W / 8);
    localparam int HALF_BYTES = LANES * (HALF_W / 8);
    localparam int BYTE_BYTES = LANES * (BYTE_W / 8);

    logic [AW-1:0] mask;

    always_comb begin
        unique case (mode)
            LD_FULL:  mask = AW'(FULL_BYTES - 1);
            LD_BC1:   mask = AW'(ONE_BYTES - 1);
            LD_BC4:   mask = AW'(GRP_BYTES - 1);
            LD_F16:   mask = AW'(HALF_BYTES - 1);
            LD_INT8:  mask = AW'(BYTE_BYTES - 1);
            LD_INT16: mask = AW'(HALF_BYTES - 1);
            default:  mask = '0;
        endcase
    end

    assign fault = !mode_is_legal(mode) || (|(addr & mask));

endmodule

// File: rtl/ldop_expander.sv
module ldop_expander
    import ldx_pkg::*;
#(
    parameter int LANES = 16,
    parameter int GROUP = 4,
    parameter int AW    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*32-1:0]     in_data,
    input  logic [AW-1:0]           in_addr,
    input  logic [2:0]              in_mode,
    input  logic                    in_sign_ext,
    output logic                    out_valid,
    output logic [LANES*32-1:0]     out_vec,
    output logic                    out_fault
);

    localparam int VEC_W = LANES * ELEM_W;

    ld_mode_e          mode;
    logic [VEC_W-1:0]  rep_vec;
    logic [VEC_W-1:0]  cnv_vec;
    logic [VEC_W-1:0]  nxt_vec;
    logic              bad;

    assign mode = ld_mode_e'(in_mode);

    ldx_replicate #(.LANES(LANES), .GROUP(GROUP)) u_rep (
        .src  (in_data),
        .mode (mode),
        .vec  (rep_vec)
    );

    ldx_upconv #(.LANES(LANES)) u_cnv (
        .src      (in_data[LANES*HALF_W-1:0]),
        .mode     (mode),
        .sign_ext (in_sign_ext),
        .vec      (cnv_vec)
    );

    ldx_align_chk #(.LANES(LANES), .GROUP(GROUP), .AW(AW)) u_aln (
        .addr  (in_addr),
        .mode  (mode),
        .fault (bad)
    );

    always_comb begin
        if (bad)                     nxt_vec = '0;
        else if (mode_is_widen(mode)) nxt_vec = cnv_vec;
        else                         nxt_vec = rep_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            out_fault <= in_valid & bad;
            out_vec   <= in_valid ? nxt_vec : '0;
        end
    end

endmodule

// File: rtl/ldop_expander_chk.sv
module ldop_expander_chk #(
    parameter int LANES = 16,
    parameter int GROUP = 4,
    parameter int AW    = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [AW-1:0]       in_addr,
    input logic [2:0]          in_mode,
    input logic                out_valid,
    input logic [LANES*32-1:0] out_vec,
    input logic                out_fault
);

    // R9 and R10: a faulting result carries an all-zero vector
    a_r9_fault_zero: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> (out_vec == '0));

    // R10: illegal codes always fault
    a_r10_illegal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[2:1] == 2'b11) |=> out_fault);

    // R11: one-clock latency of the strobe
    a_r11_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_fault && out_vec == '0));

    // R1: full load at a non-multiple of the full size faults
    a_r1_full_align: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 3'd0 && in_addr[$clog2(LANES*4)-1:0] != '0) |=> out_fault);

    // R2: single broadcast fills every lane with the same word
    a_r2_bc1_same: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 3'd1 && in_addr[1:0] == 2'b00) |=>
            (!out_fault && out_vec == {LANES{out_vec[31:0]}}));

    // R3: group broadcast repeats the first group
    a_r3_bc4_repeat: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 3'd2 && in_addr[3:0] == 4'd0) |=>
            (out_vec[GROUP*32 +: GROUP*32] == out_vec[0 +: GROUP*32]));

endmodule

bind ldop_expander ldop_expander_chk #(.LANES(LANES), .GROUP(GROUP), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .out_fault (out_fault)
);

// File: tb/ldop_expander_tb.sv
module ldop_expander_tb;

    localparam int LANES = 16;
    localparam int GROUP = 4;
    localparam int AW    = 16;
    localparam int VW    = LANES * 32;

    typedef struct {
        logic [VW-1:0] vec;
        logic          fault;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_data = '0;
    logic [AW-1:0] in_addr = '0;
    logic [2:0]    in_mode = '0;
    logic          in_sign_ext = 1'b0;
    logic          out_valid;
    logic [VW-1:0] out_vec;
    logic          out_fault;

    int   checks = 0;
    int   failures = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    ldop_expander #(.LANES(LANES), .GROUP(GROUP), .AW(AW)) u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
        .in_addr (in_addr), .in_mode (in_mode), .in_sign_ext (in_sign_ext),
        .out_valid (out_valid), .out_vec (out_vec), .out_fault (out_fault)
    );

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] got,
                         input logic [VW-1:0] exp, input logic gf, input logic ef);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: vec got %h exp %h fault got %b exp %b", tag, got, exp, gf, ef);
        end
    endtask

    // monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11 unexpected result", out_vec, '0, out_fault, 1'b0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_vec == e.vec && out_fault == e.fault, e.tag, out_vec, e.vec, out_fault, e.fault);
            end
        end
    end

    task automatic send(input logic [VW-1:0] d, input logic [AW-1:0] a, input logic [2:0] m,
                        input logic sx, input logic [VW-1:0] ev, input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_addr = a; in_mode = m; in_sign_ext = sx;
        e.vec = ef ? '0 : ev; e.fault = ef; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [VW-1:0] word_pat(input logic [31:0] seed);
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*32 +: 32] = seed ^ (32'h01030507 * (i + 1));
        return v;
    endfunction

    logic [VW-1:0] d, ev;
    logic [15:0]   hin [16];
    logic [31:0]   hout[16];

    initial begin
        hin[0]  = 16'h3C00; hout[0]  = 32'h3F800000;  // 1.0
        hin[1]  = 16'hC000; hout[1]  = 32'hC0000000;  // -2.0
        hin[2]  = 16'h0000; hout[2]  = 32'h00000000;  // +0
        hin[3]  = 16'h8000; hout[3]  = 32'h80000000;  // -0
        hin[4]  = 16'h7C00; hout[4]  = 32'h7F800000;  // +inf
        hin[5]  = 16'hFC00; hout[5]  = 32'hFF800000;  // -inf
        hin[6]  = 16'h7E00; hout[6]  = 32'h7FC00000;  // quiet NaN
        hin[7]  = 16'h7D01; hout[7]  = 32'h7FA02000;  // signalling NaN, payload
        hin[8]  = 16'h0001; hout[8]  = 32'h33800000;  // smallest subnormal
        hin[9]  = 16'h03FF; hout[9]  = 32'h387FC000;  // largest subnormal
        hin[10] = 16'h0400; hout[10] = 32'h38800000;  // smallest normal
        hin[11] = 16'h7BFF; hout[11] = 32'h477FE000;  // largest normal
        hin[12] = 16'h3555; hout[12] = 32'h3EAAA000;
        hin[13] = 16'h8001; hout[13] = 32'hB3800000;  // negative subnormal
        hin[14] = 16'h0200; hout[14] = 32'h38000000;  // subnormal 2^-15
        hin[15] = 16'h4900; hout[15] = 32'h41200000;  // 10.0
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs clear during reset
        check(out_valid == 0 && out_fault == 0 && out_vec == '0, "R12 reset", out_vec, '0, out_fault, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && out_fault == 0 && out_vec == '0, "R12 after reset", out_vec, '0, out_fault, 1'b0);

        // R1 full load
        d = word_pat(32'hA5C3_0F1E);
        send(d, 16'h0140, 3'd0, 1'b0, d, 1'b0, "R1 full aligned");
        send(d, 16'h0120, 3'd0, 1'b0, d, 1'b1, "R9 full misaligned 32");

        // R2 single broadcast
        d = word_pat(32'h1234_5678);
        for (int i = 0; i < LANES; i++) ev[i*32 +: 32] = d[31:0];
        send(d, 16'h0104, 3'd1, 1'b0, ev, 1'b0, "R2 bc1 aligned 4");
        send(d, 16'h0102, 3'd1, 1'b0, ev, 1'b1, "R9 bc1 misaligned 2");

        // R3 group broadcast
        d = word_pat(32'hDEAD_BEEF);
        for (int i = 0; i < LANES; i++) ev[i*32 +: 32] = d[(i % 4)*32 +: 32];
        send(d, 16'h0030, 3'd2, 1'b0, ev, 1'b0, "R3 bc4 aligned 16");
        send(d, 16'h0038, 3'd2, 1'b0, ev, 1'b1, "R9 bc4 misaligned 8");

        // R4 R5 R6 half-float widen
        d = word_pat(32'hFFFF_FFFF);
        for (int i = 0; i < LANES; i++) begin
            d[i*16 +: 16] = hin[i];
            ev[i*32 +: 32] = hout[i];
        end
        send(d, 16'h0060, 3'd3, 1'b0, ev, 1'b0, "R4 R5 R6 f16 aligned 32");
        send(d, 16'h0070, 3'd3, 1'b1, ev, 1'b1, "R9 f16 misaligned 16");

        // R7 byte widen, signed then unsigned
        d = word_pat(32'h7755_3311);
        for (int i = 0; i < LANES; i++) d[i*8 +: 8] = 8'(8'h85 + i * 37);
        for (int i = 0; i < LANES; i++) ev[i*32 +: 32] = 32'($signed(d[i*8 +: 8]));
        send(d, 16'h0010, 3'd4, 1'b1, ev, 1'b0, "R7 int8 signed");
        for (int i = 0; i < LANES; i++) ev[i*32 +: 32] = {24'd0, d[i*8 +: 8]};
        send(d, 16'h0010, 3'd4, 1'b0, ev, 1'b0, "R7 int8 unsigned");
        send(d, 16'h0008, 3'd4, 1'b1, ev, 1'b1, "R9 int8 misaligned 8");

        // R8 halfword widen
        for (int i = 0; i < LANES; i++) d[i*16 +: 16] = 16'(16'h8123 + i * 16'h1357);
        for (int i = 0; i < LANES; i++) ev[i*32 +: 32] = 32'($signed(d[i*16 +: 16]));
        send(d, 16'h0020, 3'd5, 1'b1, ev, 1'b0, "R8 int16 signed");
        for (int i = 0; i < LANES; i++) ev[i*32 +: 32] = {16'd0, d[i*16 +: 16]};
        send(d, 16'h0020, 3'd5, 1'b0, ev, 1'b0, "R8 int16 unsigned");
        send(d, 16'h0010, 3'd5, 1'b0, ev, 1'b1, "R9 int16 misaligned 16");

        // R10 illegal codes, even at a fully aligned address
        send(d, 16'h0000, 3'd6, 1'b0, '0, 1'b1, "R10 code 6");
        send(d, 16'h0000, 3'd7, 1'b1, '0, 1'b1, "R10 code 7");
        idle(1);

        // R11 idle cycle after the burst shows nothing
        @(negedge clk);
        check(out_valid == 0 && out_fault == 0 && out_vec == '0, "R11 idle outputs", out_vec, '0, out_fault, 1'b0);
        idle(3);
        check(sb.size() == 0, "R11 all results seen", VW'(sb.size()), '0, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule